// File: doc/BRIEF.md
# Flat and Two-Level Mapping Table Entry Writer

This block stores a single mapping entry into an in-memory table for one ID. Two tables are served: a device table, whose entries describe a per-device translation table, and a collection table, whose entries name a target processor. Each table is set up by static inputs: an enable, a layout select (flat or two-level), a base address, and the page size and entry size as base-2 logarithms. A request gives the table, the ID, an entry-valid flag and the fields to pack. The block then issues 64-bit memory accesses, one at a time, through a request/acknowledge port.

A flat table gets one write at base plus ID times the entry size. A two-level table first reads an 8-byte level-1 descriptor. The level-2 entry is written only when that descriptor is marked valid. The block ends every request with a one-cycle `done`. When a memory access fails, `err` is raised in the same cycle. A disabled table, or a level-1 descriptor that is not valid, ends the request quietly with no error.

Top module: `tbl_entry_writer`

## Requirements
- R1: A request to a table whose enable input is low produces `done` with `err` low and issues no memory access.
- R2: In flat layout the entry is written once, at base + ID × 2^entry_lg.
- R3: In two-level layout the first access is a read at base + (ID >> (page_lg − 3)) × 8.
- R4: A level-1 descriptor counts as valid when bit 63 is 1. In that case the entry is written at descriptor[50:0] + (ID mod 2^(page_lg − entry_lg)) × 2^entry_lg. Descriptor bits 62:51 are ignored.
- R5: When the level-1 descriptor has bit 63 at 0, no write follows and the request ends with `done` and `err` low.
- R6: With `req_tbl` = 0 (device table), the written word holds the valid flag in bit 0, the 5-bit size in bits 5:1 and the 44-bit translation table address in bits 49:6. All other bits are 0.
- R7: With `req_tbl` = 1 (collection table), the written word holds the valid flag in bit 0 and the 16-bit processor number in bits 16:1. All other bits are 0.
- R8: If the level-1 read is acknowledged with `mem_err` high, the request ends with `done` and `err` high and no write is issued.
- R9: If the entry write is acknowledged with `mem_err` high, the request ends with `done` and `err` high. `err` is never high without `done`.
- R10: While `mem_req` is high and not yet acknowledged, `mem_addr`, `mem_we` and `mem_wdata` hold steady. `done` is never high while a memory access is pending. `req_ready` is high only when the block is idle. Without a new request, `done` lasts exactly one cycle.
- R11: An entry whose valid flag is clear is written as all zeros, whatever the other payload fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_tbl | input | 1 | 0 = device table, 1 = collection table |
| req_id | input | ID_W | Entry ID |
| req_vld | input | 1 | Valid flag stored in the entry |
| req_size | input | 5 | Device entry size field |
| req_itt | input | 44 | Device entry translation table address |
| req_proc | input | 16 | Collection entry processor number |
| dev_tbl_valid | input | 1 | Device table enabled |
| dev_tbl_indirect | input | 1 | Device table is two-level |
| dev_tbl_base | input | ADDR_W | Device table base address |
| dev_page_lg | input | LG_W | log2 of device table page size |
| dev_entry_lg | input | LG_W | log2 of device entry size |
| col_tbl_valid | input | 1 | Collection table enabled |
| col_tbl_indirect | input | 1 | Collection table is two-level |
| col_tbl_base | input | ADDR_W | Collection table base address |
| col_page_lg | input | LG_W | log2 of collection table page size |
| col_entry_lg | input | LG_W | log2 of collection entry size |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the 64-bit access |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed, qualified by `mem_ack` |
| mem_rdata | input | 64 | Read data, qualified by `mem_ack` |
| done | output | 1 | Request finished (one-cycle pulse) |
| err | output | 1 | Request finished with a memory error |

## Verification
The assertions rely on the following. `mem_ack` comes only while `mem_req` is high, and never in the cycle after an acknowledged access. `mem_rdata` and `mem_err` are meaningful only with `mem_ack`. Each table's page_lg is at least 3 and at least its entry_lg. The bench memory model acknowledges every request exactly one cycle after it first sees it and drops the acknowledge for the following cycle. Configuration inputs change only at negative edges between requests, and all log2 values stay within the limits above.

// File: rtl/tew_pkg.sv
package tew_pkg;
    localparam int WORD_W       = 64;
    localparam int SIZE_W       = 5;
    localparam int ITT_W        = 44;
    localparam int PROC_W       = 16;
    localparam int DESC_VLD_BIT = 63;
    localparam int L2_ADDR_MSB  = 50;
    localparam int L1_DESC_LG   = 3;

    localparam logic TBL_DEV = 1'b0;
    localparam logic TBL_COL = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L1   = 2'd1,
        ST_WR   = 2'd2
    } tew_state_e;
endpackage

// File: rtl/tew_entry_pack.sv
module tew_entry_pack
    import tew_pkg::*;
(
    input  logic              tbl,
    input  logic              vld,
    input  logic [SIZE_W-1:0] size,
    input  logic [ITT_W-1:0]  itt,
    input  logic [PROC_W-1:0] proc,
    output logic [WORD_W-1:0] entry
);
    localparam int DEV_USED = 1 + SIZE_W + ITT_W;
    localparam int COL_USED = 1 + PROC_W;

    logic [WORD_W-1:0] dev_word;
    logic [WORD_W-1:0] col_word;

    always_comb begin
        dev_word = {{(WORD_W-DEV_USED){1'b0}}, itt, size, 1'b1};
        col_word = {{(WORD_W-COL_USED){1'b0}}, proc, 1'b1};
        if (!vld) begin
            entry = '0;
        end else if (tbl == TBL_COL) begin
            entry = col_word;
        end else begin
            entry = dev_word;
        end
    end
endmodule

// File: rtl/tew_addr_gen.sv
module tew_addr_gen
    import tew_pkg::*;
#(
    parameter int ID_W   = 32,
    parameter int ADDR_W = 52,
    parameter int LG_W   = 5
) (
    input  logic [ID_W-1:0]   id,
    input  logic [ADDR_W-1:0] base,
    input  logic              indirect,
    input  logic [LG_W-1:0]   page_lg,
    input  logic [LG_W-1:0]   entry_lg,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] l2_off
);
    logic [LG_W-1:0]   l1_shift;
    logic [LG_W-1:0]   l2_lg;
    logic [ID_W-1:0]   l1_idx;
    logic [ADDR_W-1:0] id_ext;
    logic [ADDR_W-1:0] l2_mask;

    always_comb begin
        id_ext   = ADDR_W'(id);
        // divide by entries per level-1 page: page / 8 descriptors
        l1_shift = page_lg - LG_W'(L1_DESC_LG);
        l1_idx   = id >> l1_shift;
        // modulo entries per level-2 page
        l2_lg    = page_lg - entry_lg;
        l2_mask  = ~({ADDR_W{1'b1}} << l2_lg);
        l2_off   = (id_ext & l2_mask) << entry_lg;
        if (indirect) begin
            first_addr = base + (ADDR_W'(l1_idx) << L1_DESC_LG);
        end else begin
            first_addr = base + (id_ext << entry_lg);
        end
    end
endmodule

// File: rtl/tbl_entry_writer.sv
module tbl_entry_writer
    import tew_pkg::*;
#(
    parameter int ID_W   = 32,
    parameter int ADDR_W = 52,
    parameter int LG_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_tbl,
    input  logic [ID_W-1:0]   req_id,
    input  logic              req_vld,
    input  logic [4:0]        req_size,
    input  logic [43:0]       req_itt,
    input  logic [15:0]       req_proc,
    input  logic              dev_tbl_valid,
    input  logic              dev_tbl_indirect,
    input  logic [ADDR_W-1:0] dev_tbl_base,
    input  logic [LG_W-1:0]   dev_page_lg,
    input  logic [LG_W-1:0]   dev_entry_lg,
    input  logic              col_tbl_valid,
    input  logic              col_tbl_indirect,
    input  logic [ADDR_W-1:0] col_tbl_base,
    input  logic [LG_W-1:0]   col_page_lg,
    input  logic [LG_W-1:0]   col_entry_lg,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [63:0]       mem_rdata,
    output logic              done,
    output logic              err
);
    typedef struct packed {
        tew_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] l2off;
        logic [WORD_W-1:0] wdata;
        logic              we;
        logic              done;
        logic              err;
    } tew_regs_t;

    tew_regs_t r_q, r_d;

    logic              sel_valid;
    logic              sel_ind;
    logic [ADDR_W-1:0] sel_base;
    logic [LG_W-1:0]   sel_page_lg;
    logic [LG_W-1:0]   sel_entry_lg;
    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] l2_off;
    logic [WORD_W-1:0] entry;
    logic              accept;

    always_comb begin
        if (req_tbl == TBL_COL) begin
            sel_valid    = col_tbl_valid;
            sel_ind      = col_tbl_indirect;
            sel_base     = col_tbl_base;
            sel_page_lg  = col_page_lg;
            sel_entry_lg = col_entry_lg;
        end else begin
            sel_valid    = dev_tbl_valid;
            sel_ind      = dev_tbl_indirect;
            sel_base     = dev_tbl_base;
            sel_page_lg  = dev_page_lg;
            sel_entry_lg = dev_entry_lg;
        end
    end

    tew_addr_gen #(
        .ID_W  (ID_W),
        .ADDR_W(ADDR_W),
        .LG_W  (LG_W)
    ) u_addr (
        .id        (req_id),
        .base      (sel_base),
        .indirect  (sel_ind),
        .page_lg   (sel_page_lg),
        .entry_lg  (sel_entry_lg),
        .first_addr(first_addr),
        .l2_off    (l2_off)
    );

    tew_entry_pack u_pack (
        .tbl  (req_tbl),
        .vld  (req_vld),
        .size (req_size),
        .itt  (req_itt),
        .proc (req_proc),
        .entry(entry)
    );

    assign req_ready = (r_q.st == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (!sel_valid) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.addr  = first_addr;
                        r_d.l2off = l2_off;
                        r_d.wdata = entry;
                        r_d.we    = !sel_ind;
                        r_d.st    = sel_ind ? ST_L1 : ST_WR;
                    end
                end
            end
            ST_L1: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else if (mem_rdata[DESC_VLD_BIT]) begin
                        r_d.addr = ADDR_W'(mem_rdata[L2_ADDR_MSB:0]) + r_q.l2off;
                        r_d.we   = 1'b1;
                        r_d.st   = ST_WR;
                    end else begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end
                end
            end
            ST_WR: begin
                if (mem_ack) begin
                    r_d.done = 1'b1;
                    r_d.err  = mem_err;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, l2off: '0, wdata: '0,
                     we: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req   = (r_q.st != ST_IDLE);
    assign mem_we    = r_q.we;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign done      = r_q.done;
    assign err       = r_q.err;

    AST_DISABLED_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !sel_valid) |=> (done && !err && !mem_req)); // R1
    AST_DESC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_L1 && mem_ack && !mem_err && !mem_rdata[DESC_VLD_BIT])
        |=> (done && !err && !mem_req)); // R5
    AST_L1_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_L1 && mem_ack && mem_err) |=> (done && err && !mem_req)); // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R9
    AST_HOLD_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata))); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_req && req_ready)); // R10
endmodule

// File: tb/tbl_entry_writer_bench.sv
module tbl_entry_writer_bench;
    localparam int ID_W   = 32;
    localparam int ADDR_W = 52;
    localparam int LG_W   = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_tbl = 1'b0;
    logic [ID_W-1:0]   req_id = '0;
    logic              req_vld = 1'b0;
    logic [4:0]        req_size = '0;
    logic [43:0]       req_itt = '0;
    logic [15:0]       req_proc = '0;
    logic              dev_tbl_valid = 1'b1;
    logic              dev_tbl_indirect = 1'b0;
    logic [ADDR_W-1:0] dev_tbl_base = 52'h1000;
    logic [LG_W-1:0]   dev_page_lg = 5'd12;
    logic [LG_W-1:0]   dev_entry_lg = 5'd3;
    logic              col_tbl_valid = 1'b1;
    logic              col_tbl_indirect = 1'b0;
    logic [ADDR_W-1:0] col_tbl_base = 52'h20000;
    logic [LG_W-1:0]   col_page_lg = 5'd12;
    logic [LG_W-1:0]   col_entry_lg = 5'd4;
    logic              mem_req;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [63:0]       mem_wdata;
    logic              mem_ack = 1'b0;
    logic              mem_err = 1'b0;
    logic [63:0]       mem_rdata = '0;
    logic              done;
    logic              err;

    // memory model controls and observations
    logic [63:0]       l1_word = '0;
    logic              rd_fail = 1'b0;
    logic              wr_fail = 1'b0;
    int                n_rd = 0;
    int                n_wr = 0;
    logic [ADDR_W-1:0] last_ra = '0;
    logic [ADDR_W-1:0] last_wa = '0;
    logic [63:0]       last_wd = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tbl_entry_writer #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LG_W(LG_W)) u_tbl_entry_writer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_tbl(req_tbl), .req_id(req_id), .req_vld(req_vld), .req_size(req_size),
        .req_itt(req_itt), .req_proc(req_proc),
        .dev_tbl_valid(dev_tbl_valid), .dev_tbl_indirect(dev_tbl_indirect),
        .dev_tbl_base(dev_tbl_base), .dev_page_lg(dev_page_lg), .dev_entry_lg(dev_entry_lg),
        .col_tbl_valid(col_tbl_valid), .col_tbl_indirect(col_tbl_indirect),
        .col_tbl_base(col_tbl_base), .col_page_lg(col_page_lg), .col_entry_lg(col_entry_lg),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .done(done), .err(err)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                n_wr    <= n_wr + 1;
                last_wa <= mem_addr;
                last_wd <= mem_wdata;
                mem_err <= wr_fail;
            end else begin
                n_rd      <= n_rd + 1;
                last_ra   <= mem_addr;
                mem_rdata <= l1_word;
                mem_err   <= rd_fail;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // issue one request, wait for done; returns err seen with done and pulse check
    task automatic run_req(input logic tbl, input logic [ID_W-1:0] id, input logic vld,
                           input logic [4:0] size, input logic [43:0] itt,
                           input logic [15:0] proc, output logic got_err,
                           output int rd_cnt, output int wr_cnt);
        int rd0 = n_rd;
        int wr0 = n_wr;
        int waited = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_tbl = tbl; req_id = id; req_vld = vld;
        req_size = size; req_itt = itt; req_proc = proc;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && waited < 1000) begin
            @(negedge clk);
            waited++;
        end
        if (!done) begin
            check("R10 watchdog done", 64'd0, 64'd1);
            got_err = 1'b0;
        end else begin
            got_err = err;
        end
        rd_cnt = n_rd - rd0;
        wr_cnt = n_wr - wr0;
        @(negedge clk);
        check("R10 done one cycle", {63'd0, done}, 64'd0);
    endtask

    task automatic t_reset;
        check("R10 reset ready", {63'd0, req_ready}, 64'd1);
        check("R10 reset mem_req", {63'd0, mem_req}, 64'd0);
        check("R10 reset done", {63'd0, done}, 64'd0);
    endtask

    task automatic t_disabled;
        logic e; int r; int w;
        dev_tbl_valid = 1'b0;
        run_req(1'b0, 32'd7, 1'b1, 5'd3, 44'h123, 16'h0, e, r, w);
        check("R1 no error", {63'd0, e}, 64'd0);
        check("R1 no reads", 64'(r), 64'd0);
        check("R1 no writes", 64'(w), 64'd0);
        dev_tbl_valid = 1'b1;
    endtask

    task automatic t_flat_dev;
        logic e; int r; int w;
        logic [43:0] itt = 44'hABC_DE12_3456;
        run_req(1'b0, 32'd5, 1'b1, 5'h11, itt, 16'hFFFF, e, r, w);
        check("R2 one write", 64'(w), 64'd1);
        check("R2 no read", 64'(r), 64'd0);
        check("R2 flat address", 64'(last_wa), 64'(dev_tbl_base) + 64'd5 * 64'd8);
        check("R6 device entry", last_wd,
              64'd1 + (64'h11 * 64'd2) + (64'(itt) * 64'd64));
        check("R9 no error", {63'd0, e}, 64'd0);
    endtask

    task automatic t_flat_col;
        logic e; int r; int w;
        run_req(1'b1, 32'd2, 1'b1, 5'h1F, 44'hFFF, 16'hBEEF, e, r, w);
        check("R2 collection address", 64'(last_wa), 64'(col_tbl_base) + 64'd2 * 64'd16);
        check("R7 collection entry", last_wd, 64'd1 + 64'hBEEF * 64'd2);
        run_req(1'b1, 32'd3, 1'b0, 5'h1F, 44'hFFF, 16'h1234, e, r, w);
        check("R11 cleared collection entry", last_wd, 64'd0);
        check("R2 collection address 2", 64'(last_wa), 64'(col_tbl_base) + 64'd3 * 64'd16);
        run_req(1'b0, 32'd9, 1'b0, 5'h1F, 44'hFFF_FFFF_FFFF, 16'h1234, e, r, w);
        check("R11 cleared device entry", last_wd, 64'd0);
    endtask

    task automatic t_indirect_ok;
        logic e; int r; int w;
        logic [ID_W-1:0] id = 32'd1029;
        logic [63:0] l2base = 64'h50_0000;
        dev_tbl_indirect = 1'b1;
        l1_word = 64'h8000_0000_0000_0000 | 64'h0008_0000_0000_0000 | l2base;
        run_req(1'b0, id, 1'b1, 5'h02, 44'h77, 16'h0, e, r, w);
        check("R3 one read", 64'(r), 64'd1);
        check("R3 level-1 address", 64'(last_ra),
              64'(dev_tbl_base) + (64'(id) / (64'd4096 / 64'd8)) * 64'd8);
        check("R4 one write", 64'(w), 64'd1);
        check("R4 level-2 address", 64'(last_wa),
              l2base + (64'(id) % (64'd4096 / 64'd8)) * 64'd8);
        check("R6 indirect entry", last_wd, 64'd1 + 64'd4 + 64'h77 * 64'd64);
        // collection two-level with 16-byte entries
        col_tbl_indirect = 1'b1;
        l1_word = 64'h8000_0000_0012_3000;
        run_req(1'b1, 32'd700, 1'b1, 5'h0, 44'h0, 16'h00A5, e, r, w);
        check("R3 collection level-1 address", 64'(last_ra),
              64'(col_tbl_base) + (64'd700 / 64'd512) * 64'd8);
        check("R4 collection level-2 address", 64'(last_wa),
              64'h12_3000 + (64'd700 % (64'd4096 / 64'd16)) * 64'd16);
        col_tbl_indirect = 1'b0;
    endtask

    task automatic t_indirect_off;
        logic e; int r; int w;
        l1_word = 64'h7FFF_FFFF_FFFF_FFFF;
        run_req(1'b0, 32'd12, 1'b1, 5'h1, 44'h1, 16'h0, e, r, w);
        check("R5 read issued", 64'(r), 64'd1);
        check("R5 no write", 64'(w), 64'd0);
        check("R5 no error", {63'd0, e}, 64'd0);
    endtask

    task automatic t_l1_fail;
        logic e; int r; int w;
        l1_word = 64'h8000_0000_0000_1000;
        rd_fail = 1'b1;
        run_req(1'b0, 32'd4, 1'b1, 5'h1, 44'h1, 16'h0, e, r, w);
        check("R8 error", {63'd0, e}, 64'd1);
        check("R8 no write", 64'(w), 64'd0);
        rd_fail = 1'b0;
        dev_tbl_indirect = 1'b0;
    endtask

    task automatic t_wr_fail;
        logic e; int r; int w;
        wr_fail = 1'b1;
        run_req(1'b1, 32'd1, 1'b1, 5'h0, 44'h0, 16'h0042, e, r, w);
        check("R9 write error", {63'd0, e}, 64'd1);
        check("R9 write attempted", 64'(w), 64'd1);
        wr_fail = 1'b0;
        run_req(1'b1, 32'd1, 1'b1, 5'h0, 44'h0, 16'h0042, e, r, w);
        check("R9 error cleared", {63'd0, e}, 64'd0);
    endtask

    task automatic t_busy;
        int waited = 0;
        @(negedge clk);
        req_tbl = 1'b0; req_id = 32'd1; req_vld = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        check("R10 ready low while busy", {63'd0, req_ready}, 64'd0);
        check("R10 mem_req high while busy", {63'd0, mem_req}, 64'd1);
        req_valid = 1'b0;
        while (!done && waited < 1000) begin
            @(negedge clk);
            waited++;
        end
        check("R10 busy request done", {63'd0, done}, 64'd1);
    endtask

    initial begin
        #2_000_000;
        check("R10 global watchdog", 64'd0, 64'd1);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_flat_dev();
        t_flat_col();
        t_indirect_ok();
        t_indirect_off();
        t_l1_fail();
        t_wr_fail();
        t_busy();
        repeat (3) @(negedge clk);
        summary();
    end
endmodule